// File: doc/BRIEF.md
# Eight-Stage Pipeline Interlock Controller

This block makes the hazard decisions for an in-order integer pipeline with eight stages: two fetch stages, register read (RF), execute (EX), two data-cache stages (DF, DS), tag check (TC) and write-back (WB). Every cycle it looks at the source registers of the instruction in RF and at the destinations and load flags of the instructions in EX, DF and DS. From these it chooses a forwarding source for each operand, and it holds the front of the pipe when a load result cannot arrive in time. Load data is forwarded at the end of DS, before its tag check. A consumer right behind a load therefore waits two cycles, and a consumer with one unrelated instruction in between waits one cycle.

Branches resolve in EX. A taken branch kills the two fall-through fetches still in the fetch stages, while its delay slot in RF runs. The likely branch form instead turns its delay slot into a bubble when it is not taken. The controller keeps its own copy of the branch flags as an instruction moves from RF to EX. It also keeps a copy of the DS stage, so it knows which register and which load sit in TC. If that load misses in the tag check, the controller asserts restart. Restart flushes everything younger than the load, because a consumer may already have used the bad forwarded data, and it stays high until the refill engine reports completion. The controller then pulses replay, so that fetch resumes at the instruction after the load.

Top module: `pipe_interlock_ctl`

## Requirements
- R1: Each operand select is 0 (register file) when no older in-flight writer matches its source. Otherwise it names the youngest matching writer: 1 = EX/DF latch (writer in EX), 2 = DF/DS latch (writer in DF), 3 = DS/TC latch (writer in DS), 4 = TC/WB latch (writer in TC, tracked internally from the previous cycle's DS).
- R2: A source register of 0 always gets select 0 and never causes a stall, whatever the stages hold.
- R3: `stall` is high when RF holds a valid instruction and one of its sources matches a writing load in EX or DF. A load in DS or TC causes no stall and is forwarded instead. A stage whose write flag is low never matches.
- R4: Whenever `stall` is high, `bubble_ex` is also high, which sends an empty slot into EX.
- R5: A branch that entered EX from RF and is reported taken (`ex_taken`=1) raises `fetch_kill` for exactly that one cycle, and `slot_cancel` stays low. A not-taken ordinary branch raises neither.
- R6: A likely branch in EX that is not taken raises `slot_cancel` and `bubble_ex` and forces `stall` low in that cycle. A taken likely branch acts like R5.
- R7: A branch held in RF by a stall does not enter EX in that cycle, so it cannot raise `fetch_kill` in the next cycle.
- R8: A load in TC with `tc_hit`=0 raises `restart` in the same cycle. `restart` stays high until the cycle with `refill_done`=1, in which `replay` pulses, and it is low the cycle after.
- R9: While `restart` is high, `stall`, `fetch_kill` and `slot_cancel` are low. Branch and TC tracking are cleared, so no branch seen during restart can cause a kill afterwards.
- R10: In reset, `restart`, `replay`, `fetch_kill` and `slot_cancel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_valid | input | 1 | RF holds a real instruction |
| rf_src_a | input | REG_W | First source register of the RF instruction |
| rf_src_b | input | REG_W | Second source register of the RF instruction |
| rf_is_branch | input | 1 | RF instruction is a branch |
| rf_is_likely | input | 1 | RF branch is the likely form |
| stg_wr | input | NSTG | Write flag per stage; bit 0 EX, 1 DF, 2 DS |
| stg_dst | input | NSTG*REG_W | Destination per stage, REG_W bits each, EX lowest |
| stg_load | input | NSTG | Load flag per stage, same order |
| ex_taken | input | 1 | Branch outcome resolved in EX |
| tc_hit | input | 1 | Data cache tag check result in TC |
| refill_done | input | 1 | Refill engine has finished after a miss |
| stall | output | 1 | Hold IF, IS and RF this cycle |
| bubble_ex | output | 1 | Send an empty slot into EX |
| fetch_kill | output | 1 | Squash the two fall-through fetches in IF and IS |
| slot_cancel | output | 1 | Squash the delay slot in RF |
| fwd_sel_a | output | SEL_W | Forwarding select for operand A |
| fwd_sel_b | output | SEL_W | Forwarding select for operand B |
| restart | output | 1 | Flush everything younger than the missing load |
| replay | output | 1 | Resume fetch after the missing load |

## Verification
The in-module assertions check the rules that hold in every cycle. A stall only occurs with a valid RF instruction, and a writing load in EX that matches a nonzero source always stalls unless restart or a cancel overrides it. Register 0 never selects a forward. Restart holds until the refill finishes and releases right after replay, and the stall, kill and cancel outputs stay quiet while restart is high. Other behaviour only shows up in the bench scenarios, because it depends on history: the youngest-wins priority across all four latches, forwarding from the TC copy one cycle after a DS writer, the single-cycle kill of a branch that entered EX, a branch held by a stall raising no kill, and the clearing of branch tracking across a restart.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Stage positions in the per-stage input vectors; TC is the internal copy.
  localparam int STG_EX = 0;
  localparam int STG_DF = 1;
  localparam int STG_DS = 2;

  typedef enum logic [0:0] {
    RS_RUN  = 1'b0,
    RS_WAIT = 1'b1
  } rs_state_e;
endpackage

// File: rtl/ilk_fwd_pick.sv
module ilk_fwd_pick #(
  parameter int REG_W       = 5,
  parameter int NPROD       = 4,
  parameter int LOAD_SHADOW = 2,
  parameter int SEL_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_W-1:0]       src,
  input  logic [NPROD-1:0]       prod_wr,
  input  logic [NPROD*REG_W-1:0] prod_dst,
  input  logic [NPROD-1:0]       prod_load,
  output logic [SEL_W-1:0]       sel,
  output logic                   load_near
);
  logic [NPROD-1:0] hit;

  for (genvar k = 0; k < NPROD; k++) begin : g_match
    assign hit[k] = prod_wr[k] && (prod_dst[k*REG_W +: REG_W] == src) && (src != '0);
  end

  // Youngest producer (lowest index) wins: walk oldest to youngest.
  always_comb begin
    sel = '0;
    for (int k = NPROD - 1; k >= 0; k--) begin
      if (hit[k]) sel = SEL_W'(k + 1);
    end
  end

  // Loads that have not yet reached the end of DS cannot be forwarded.
  always_comb begin
    load_near = 1'b0;
    for (int k = 0; k < LOAD_SHADOW; k++) begin
      if (hit[k] && prod_load[k]) load_near = 1'b1;
    end
  end

  AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == '0) && !load_near); // R2
endmodule

// File: rtl/ilk_branch_track.sv
module ilk_branch_track (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic rf_is_branch,
  input  logic rf_is_likely,
  input  logic flush,
  input  logic ex_taken,
  output logic fetch_kill,
  output logic slot_cancel
);
  logic br_q, br_d;
  logic lk_q, lk_d;

  always_comb begin
    if (flush) begin
      br_d = 1'b0;
      lk_d = 1'b0;
    end else begin
      br_d = advance && rf_is_branch;
      lk_d = advance && rf_is_branch && rf_is_likely;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_q <= 1'b0;
      lk_q <= 1'b0;
    end else begin
      br_q <= br_d;
      lk_q <= lk_d;
    end
  end

  assign fetch_kill  = br_q && ex_taken && !flush;
  assign slot_cancel = br_q && lk_q && !ex_taken && !flush;

  AST_KILL_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kill |-> ex_taken && !slot_cancel); // R5
endmodule

// File: rtl/ilk_tc_restart.sv
module ilk_tc_restart #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ds_wr,
  input  logic [REG_W-1:0] ds_dst,
  input  logic             ds_load,
  input  logic             tc_hit,
  input  logic             refill_done,
  output logic             tc_wr,
  output logic [REG_W-1:0] tc_dst,
  output logic             tc_load,
  output logic             restart,
  output logic             replay
);
  import ilk_pkg::*;

  rs_state_e        st_q, st_d;
  logic             miss;
  logic             wr_d, ld_d;
  logic [REG_W-1:0] dst_d;
  logic             dst_en;

  assign miss    = tc_wr && tc_load && !tc_hit && (st_q == RS_RUN);
  assign restart = (st_q == RS_WAIT) || miss;
  assign replay  = (st_q == RS_WAIT) && refill_done;

  always_comb begin
    st_d = st_q;
    case (st_q)
      RS_RUN:  if (miss) st_d = RS_WAIT;
      RS_WAIT: if (refill_done) st_d = RS_RUN;
      default: st_d = RS_RUN;
    endcase
  end

  // TC copy: whatever DS holds moves on, unless it is flushed.
  always_comb begin
    wr_d   = ds_wr && !restart;
    ld_d   = ds_load && !restart;
    dst_en = ds_wr && !restart;
    dst_d  = ds_dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_RUN;
      tc_wr   <= 1'b0;
      tc_load <= 1'b0;
      tc_dst  <= '0;
    end else begin
      st_q    <= st_d;
      tc_wr   <= wr_d;
      tc_load <= ld_d;
      if (dst_en) tc_dst <= dst_d;
    end
  end

  AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !refill_done) |=> restart); // R8
  AST_REPLAY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (st_q == RS_RUN)); // R8
endmodule

// File: rtl/pipe_interlock_ctl.sv
module pipe_interlock_ctl #(
  parameter int REG_W       = 5,
  parameter int NSTG        = 3,
  parameter int LOAD_SHADOW = 2,
  localparam int NPROD      = NSTG + 1,
  localparam int SEL_W      = $clog2(NPROD + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rf_valid,
  input  logic [REG_W-1:0]      rf_src_a,
  input  logic [REG_W-1:0]      rf_src_b,
  input  logic                  rf_is_branch,
  input  logic                  rf_is_likely,
  input  logic [NSTG-1:0]       stg_wr,
  input  logic [NSTG*REG_W-1:0] stg_dst,
  input  logic [NSTG-1:0]       stg_load,
  input  logic                  ex_taken,
  input  logic                  tc_hit,
  input  logic                  refill_done,
  output logic                  stall,
  output logic                  bubble_ex,
  output logic                  fetch_kill,
  output logic                  slot_cancel,
  output logic [SEL_W-1:0]      fwd_sel_a,
  output logic [SEL_W-1:0]      fwd_sel_b,
  output logic                  restart,
  output logic                  replay
);
  import ilk_pkg::*;

  logic             tc_wr, tc_load;
  logic [REG_W-1:0] tc_dst;
  logic [NPROD-1:0]       prod_wr, prod_load;
  logic [NPROD*REG_W-1:0] prod_dst;
  logic near_a, near_b, hazard, advance;

  ilk_tc_restart #(.REG_W(REG_W)) u_tc (
    .clk(clk), .rst_n(rst_n),
    .ds_wr(stg_wr[STG_DS]),
    .ds_dst(stg_dst[STG_DS*REG_W +: REG_W]),
    .ds_load(stg_load[STG_DS]),
    .tc_hit(tc_hit), .refill_done(refill_done),
    .tc_wr(tc_wr), .tc_dst(tc_dst), .tc_load(tc_load),
    .restart(restart), .replay(replay)
  );

  // Producer list, youngest first: EX, DF, DS from the ports, TC from the copy.
  assign prod_wr   = {tc_wr, stg_wr};
  assign prod_load = {tc_load, stg_load};
  assign prod_dst  = {tc_dst, stg_dst};

  ilk_fwd_pick #(.REG_W(REG_W), .NPROD(NPROD), .LOAD_SHADOW(LOAD_SHADOW), .SEL_W(SEL_W)) u_fwd_a (
    .clk(clk), .rst_n(rst_n), .src(rf_src_a),
    .prod_wr(prod_wr), .prod_dst(prod_dst), .prod_load(prod_load),
    .sel(fwd_sel_a), .load_near(near_a)
  );

  ilk_fwd_pick #(.REG_W(REG_W), .NPROD(NPROD), .LOAD_SHADOW(LOAD_SHADOW), .SEL_W(SEL_W)) u_fwd_b (
    .clk(clk), .rst_n(rst_n), .src(rf_src_b),
    .prod_wr(prod_wr), .prod_dst(prod_dst), .prod_load(prod_load),
    .sel(fwd_sel_b), .load_near(near_b)
  );

  ilk_branch_track u_br (
    .clk(clk), .rst_n(rst_n),
    .advance(advance),
    .rf_is_branch(rf_is_branch), .rf_is_likely(rf_is_likely),
    .flush(restart), .ex_taken(ex_taken),
    .fetch_kill(fetch_kill), .slot_cancel(slot_cancel)
  );

  assign hazard    = rf_valid && (near_a || near_b);
  assign stall     = hazard && !slot_cancel && !restart;
  assign bubble_ex = stall || slot_cancel;
  assign advance   = rf_valid && !stall && !slot_cancel;

  AST_STALL_NEEDS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> rf_valid); // R3
  AST_LOAD_EX_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !restart && !slot_cancel && stg_wr[STG_EX] && stg_load[STG_EX]
     && rf_src_a != '0 && rf_src_a == stg_dst[STG_EX*REG_W +: REG_W]) |-> stall); // R3
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !stall && !fetch_kill && !slot_cancel); // R9
  AST_CANCEL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cancel |-> bubble_ex && !stall); // R6
endmodule

// File: tb/sim_pipe_interlock_ctl.sv
module sim_pipe_interlock_ctl;
  localparam int REG_W = 5;
  localparam int NSTG  = 3;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic        v;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [2:0]  wr;
    logic [2:0]  ld;
    logic [14:0] dst;
    logic        st;
    logic [2:0]  sa;
    logic [2:0]  sb;
  } vec_t;

  localparam logic [14:0] D123 = {5'd3, 5'd2, 5'd1};
  localparam logic [14:0] D7   = {5'd7, 5'd7, 5'd7};
  localparam logic [14:0] D0   = 15'd0;

  // v, a, b, wr, ld, dst -> stall, sel_a, sel_b ; tc_hit held high
  localparam vec_t VECS [12] = '{
    '{1'b1, 5'd5, 5'd6, 3'b111, 3'b000, D123, 1'b0, 3'd0, 3'd0},
    '{1'b1, 5'd1, 5'd2, 3'b111, 3'b000, D123, 1'b0, 3'd1, 3'd2},
    '{1'b1, 5'd3, 5'd9, 3'b111, 3'b000, D123, 1'b0, 3'd3, 3'd0},
    '{1'b1, 5'd7, 5'd0, 3'b111, 3'b000, D7,   1'b0, 3'd1, 3'd0},
    '{1'b1, 5'd7, 5'd7, 3'b100, 3'b000, D7,   1'b0, 3'd3, 3'd3},
    '{1'b1, 5'd0, 5'd0, 3'b111, 3'b111, D0,   1'b0, 3'd0, 3'd0},
    '{1'b1, 5'd1, 5'd9, 3'b111, 3'b001, D123, 1'b1, 3'd1, 3'd0},
    '{1'b1, 5'd9, 5'd2, 3'b111, 3'b010, D123, 1'b1, 3'd0, 3'd2},
    '{1'b1, 5'd3, 5'd9, 3'b111, 3'b100, D123, 1'b0, 3'd3, 3'd0},
    '{1'b0, 5'd1, 5'd9, 3'b111, 3'b001, D123, 1'b0, 3'd1, 3'd0},
    '{1'b1, 5'd1, 5'd9, 3'b000, 3'b001, D123, 1'b0, 3'd0, 3'd0},
    '{1'b1, 5'd9, 5'd9, 3'b000, 3'b000, D123, 1'b0, 3'd0, 3'd0}
  };

  logic clk, rst_n;
  logic rf_valid, rf_is_branch, rf_is_likely;
  logic [REG_W-1:0] rf_src_a, rf_src_b;
  logic [NSTG-1:0] stg_wr, stg_load;
  logic [NSTG*REG_W-1:0] stg_dst;
  logic ex_taken, tc_hit, refill_done;
  logic stall, bubble_ex, fetch_kill, slot_cancel, restart, replay;
  logic [SEL_W-1:0] fwd_sel_a, fwd_sel_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pipe_interlock_ctl #(.REG_W(REG_W), .NSTG(NSTG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rf_valid(rf_valid), .rf_src_a(rf_src_a), .rf_src_b(rf_src_b),
    .rf_is_branch(rf_is_branch), .rf_is_likely(rf_is_likely),
    .stg_wr(stg_wr), .stg_dst(stg_dst), .stg_load(stg_load),
    .ex_taken(ex_taken), .tc_hit(tc_hit), .refill_done(refill_done),
    .stall(stall), .bubble_ex(bubble_ex), .fetch_kill(fetch_kill),
    .slot_cancel(slot_cancel), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .restart(restart), .replay(replay)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic idle();
    rf_valid = 1'b0; rf_src_a = '0; rf_src_b = '0;
    rf_is_branch = 1'b0; rf_is_likely = 1'b0;
    stg_wr = '0; stg_load = '0; stg_dst = '0;
    ex_taken = 1'b0; tc_hit = 1'b1; refill_done = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "restart in reset", int'(restart), 0);
    chk("R10", "replay in reset", int'(replay), 0);
    chk("R10", "kill in reset", int'(fetch_kill), 0);
    chk("R10", "cancel in reset", int'(slot_cancel), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: forwarding priority and load interlock (R1, R2, R3, R4)
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rf_valid = VECS[i].v; rf_src_a = VECS[i].a; rf_src_b = VECS[i].b;
      stg_wr = VECS[i].wr; stg_load = VECS[i].ld; stg_dst = VECS[i].dst;
      #1;
      chk("R3", $sformatf("vec%0d stall", i), int'(stall), int'(VECS[i].st));
      chk("R4", $sformatf("vec%0d bubble", i), int'(bubble_ex), int'(VECS[i].st));
      chk("R1", $sformatf("vec%0d sel_a", i), int'(fwd_sel_a), int'(VECS[i].sa));
      chk("R1", $sformatf("vec%0d sel_b", i), int'(fwd_sel_b), int'(VECS[i].sb));
    end

    // R2: register 0 with every stage writing r0 as a load
    @(negedge clk); idle();
    rf_valid = 1'b1; stg_wr = 3'b111; stg_load = 3'b111; stg_dst = D0;
    #1;
    chk("R2", "r0 stall", int'(stall), 0);
    chk("R2", "r0 sel_a", int'(fwd_sel_a), 0);

    // R1: TC copy forwards one cycle after a DS writer
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_src_a = 5'd5;
    stg_wr = 3'b100; stg_load = 3'b100; stg_dst = {5'd12, 5'd0, 5'd0};
    #1;
    chk("R1", "DS r12 other src", int'(fwd_sel_a), 0);
    @(negedge clk);
    stg_wr = '0; stg_load = '0; stg_dst = '0; rf_src_a = 5'd12;
    #1;
    chk("R1", "TC/WB select", int'(fwd_sel_a), 4);
    chk("R3", "TC load no stall", int'(stall), 0);

    // R3: load-use back to back gives two stalls, then DS forward
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_src_b = 5'd9;
    stg_wr = 3'b001; stg_load = 3'b001; stg_dst = {5'd0, 5'd0, 5'd9};
    #1; chk("R3", "load in EX", int'(stall), 1);
    @(negedge clk);
    stg_wr = 3'b010; stg_load = 3'b010; stg_dst = {5'd0, 5'd9, 5'd0};
    #1; chk("R3", "load in DF", int'(stall), 1);
    @(negedge clk);
    stg_wr = 3'b100; stg_load = 3'b100; stg_dst = {5'd9, 5'd0, 5'd0};
    #1;
    chk("R3", "load in DS", int'(stall), 0);
    chk("R3", "load in DS sel_b", int'(fwd_sel_b), 3);

    // R5: ordinary taken branch
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_is_branch = 1'b1;
    @(negedge clk);
    rf_is_branch = 1'b0; ex_taken = 1'b1;
    #1;
    chk("R5", "taken kill", int'(fetch_kill), 1);
    chk("R5", "taken no cancel", int'(slot_cancel), 0);
    @(negedge clk);
    #1; chk("R5", "kill one cycle", int'(fetch_kill), 0);

    // R5: ordinary not-taken branch
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_is_branch = 1'b1;
    @(negedge clk);
    rf_is_branch = 1'b0; ex_taken = 1'b0;
    #1;
    chk("R5", "not taken kill", int'(fetch_kill), 0);
    chk("R5", "not taken cancel", int'(slot_cancel), 0);

    // R6: likely not taken, delay slot with a load hazard
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_is_branch = 1'b1; rf_is_likely = 1'b1;
    @(negedge clk);
    rf_is_branch = 1'b0; rf_is_likely = 1'b0; ex_taken = 1'b0;
    rf_src_a = 5'd1; stg_wr = 3'b001; stg_load = 3'b001; stg_dst = D123;
    #1;
    chk("R6", "likely cancel", int'(slot_cancel), 1);
    chk("R6", "likely bubble", int'(bubble_ex), 1);
    chk("R6", "likely no stall", int'(stall), 0);

    // R6: likely taken
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_is_branch = 1'b1; rf_is_likely = 1'b1;
    @(negedge clk);
    rf_is_branch = 1'b0; rf_is_likely = 1'b0; ex_taken = 1'b1;
    #1;
    chk("R6", "likely taken kill", int'(fetch_kill), 1);
    chk("R6", "likely taken cancel", int'(slot_cancel), 0);

    // R7: branch stalled in RF does not enter EX
    @(negedge clk); idle();
    rf_valid = 1'b1; rf_is_branch = 1'b1; rf_src_a = 5'd1;
    stg_wr = 3'b001; stg_load = 3'b001; stg_dst = D123;
    #1; chk("R7", "branch stalled", int'(stall), 1);
    @(negedge clk); idle();
    rf_valid = 1'b1; ex_taken = 1'b1;
    #1; chk("R7", "no kill after stall", int'(fetch_kill), 0);

    // R8, R9: tag-check miss restart
    @(negedge clk); idle();
    stg_wr = 3'b100; stg_load = 3'b100; stg_dst = {5'd12, 5'd0, 5'd0};
    @(negedge clk); idle();
    tc_hit = 1'b0; rf_valid = 1'b1; rf_src_a = 5'd1;
    stg_wr = 3'b001; stg_load = 3'b001; stg_dst = D123;
    #1;
    chk("R8", "restart same cycle", int'(restart), 1);
    chk("R9", "no stall in restart", int'(stall), 0);
    @(negedge clk);
    tc_hit = 1'b1; rf_is_branch = 1'b1;
    #1;
    chk("R8", "restart held", int'(restart), 1);
    chk("R8", "no early replay", int'(replay), 0);
    chk("R9", "stall held low", int'(stall), 0);
    @(negedge clk);
    refill_done = 1'b1;
    #1;
    chk("R8", "replay pulse", int'(replay), 1);
    chk("R8", "restart on replay", int'(restart), 1);
    @(negedge clk); idle();
    rf_valid = 1'b1; ex_taken = 1'b1;
    #1;
    chk("R8", "restart released", int'(restart), 0);
    chk("R9", "branch cleared", int'(fetch_kill), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule